// File: doc/BRIEF.md
# Multi-Core Interrupt Distributor

This block keeps the lifecycle state of up to 64 interrupt IDs and hands them out to two processor cores. Every ID is either idle, pending, active, or active with a fresh pending request behind it. IDs 0 to 15 are software-raised requests between cores. IDs 16 to 31 are private lines that belong to a single core. IDs 32 and up are shared peripheral lines. The low 32 IDs are held separately for each core, so the same low ID can be pending on one core and idle on the other. A shared ID has one state that all cores see, and the block records which core took it.

Each core has a small interface. It has a priority mask and an active-low request line. It shows the ID that would be handed out next, and it takes acknowledge and end-of-interrupt strobes. A lower priority number is more urgent, and the lower ID wins a tie. A pending shared ID whose target list names several cores goes only to targets that are not servicing anything, as long as at least one such target exists. If every target is busy, it goes to all of them. A single write port sets per-ID enables, priorities and shared target masks, and raises software requests.

Top module: `intr_dist`

## Requirements
- R1: After reset every `irq_n` bit is 1, and every `pend_id` and `ack_id` field reads 1023. Reset also clears all enables, priorities and targets.
- R2: A pending ID is presented to a core when four things hold: it is enabled, its priority is below that core's mask, it is pending on that core, and for a shared ID the core is picked by R8. The ID then appears on `pend_id` and `irq_n` goes low. A shared ID becomes pending one edge after a 0-to-1 change on its `spi_line` bit (bit j is ID 32+j).
- R3: Among the presentable IDs, the one with the smallest priority value is presented. Between equal priorities, the smaller ID is presented.
- R4: An ID whose priority is greater than or equal to the core's 4-bit mask field is never presented. A mask of 0 keeps `irq_n` high.
- R5: `ack` moves the presented ID from pending to active, and `ack_id` shows that ID after the edge. An `ack` while nothing is presented returns 1023 and changes no state.
- R6: A new request on an active ID makes it active-and-pending, and it is not presented again. End-of-interrupt (`eoi` with `eoi_id`) on that core turns active into idle and active-and-pending into pending. For a shared ID, only the core that acknowledged it can end it.
- R7: A write with kind 3 to an ID below 16 marks that ID pending on every core whose bit is set in `cfg_wdata[1:0]`. Core k's private line bit p (`ppi_line[16k+p]`) sets ID 16+p pending on core k only, on a 0-to-1 change.
- R8: A core is busy while it has any active or active-and-pending ID. A pending shared ID goes to a core whose target bit is set, but only if that core is free or none of its targets is free.
- R9: If several cores acknowledge the same shared ID in one cycle, the lowest-numbered core receives it. The others get 1023.
- R10: The enable gates only presentation. A disabled ID still records its pending state, and it is presented once kind-0 writes `cfg_wdata[0]=1`. Kind 1 sets the priority from `cfg_wdata[3:0]`. Kind 2 sets a shared ID's target mask from `cfg_wdata[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_line | input | NID-32 | Shared peripheral request lines, bit j is ID 32+j |
| ppi_line | input | NCORE*16 | Private lines, bits 16k..16k+15 belong to core k |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 enable, 1 priority, 2 target, 3 software request |
| cfg_id | input | log2(NID) | ID addressed by the write |
| cfg_wdata | input | 8 | Write data |
| pri_mask | input | NCORE*PW | Per-core priority mask |
| ack | input | NCORE | Per-core acknowledge strobe |
| eoi | input | NCORE | Per-core end-of-interrupt strobe |
| eoi_id | input | NCORE*10 | Per-core ID being ended |
| irq_n | output | NCORE | Per-core active-low request |
| pend_id | output | NCORE*10 | Per-core presented ID, 1023 if none |
| ack_id | output | NCORE*10 | Per-core ID returned by the last acknowledge |

## Verification
Two things can happen to the same shared ID in one cycle: both cores can acknowledge it, and a new request can arrive on an ID at the same edge that acknowledges or ends it. The bench first drives both cores into a busy state, so that one shared ID is shown to both cores. It then acknowledges that ID on both cores in the same cycle and expects the lower core to win and the other to get 1023. The random phase draws acks, ends, line edges and writes from a small pool of IDs, so these collisions happen often. Every cycle it compares both cores' outputs against a model derived from the lifecycle and steering rules.

// File: rtl/intr_dist_pkg.sv
package intr_dist_pkg;

    localparam int BANKED_IDS = 32;
    localparam int SGI_IDS    = 16;
    localparam int PPI_IDS    = BANKED_IDS - SGI_IDS;
    localparam int ID_OUT_W   = 10;
    localparam int SPURIOUS   = 1023;
    localparam int CFG_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND    = 2'd1,
        ST_ACT     = 2'd2,
        ST_ACTPEND = 2'd3
    } irq_state_e;

    typedef enum logic [1:0] {
        CFG_ENABLE   = 2'd0,
        CFG_PRIORITY = 2'd1,
        CFG_TARGET   = 2'd2,
        CFG_SOFTREQ  = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic                valid;
        logic [ID_OUT_W-1:0] id;
    } pick_t;

    function automatic logic is_active(irq_state_e s);
        return (s == ST_ACT) || (s == ST_ACTPEND);
    endfunction

    // lifecycle step: set = new request, take = acknowledge, done = end
    function automatic irq_state_e state_next(irq_state_e cur, logic set, logic take, logic done);
        irq_state_e n;
        unique case (cur)
            ST_IDLE: n = set ? ST_PEND : ST_IDLE;
            ST_PEND: n = take ? (set ? ST_ACTPEND : ST_ACT) : ST_PEND;
            ST_ACT:  n = done ? (set ? ST_PEND : ST_IDLE) : (set ? ST_ACTPEND : ST_ACT);
            default: n = done ? ST_PEND : ST_ACTPEND;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/intr_dist_cfg.sv
module intr_dist_cfg
    import intr_dist_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int NID   = 64,
    parameter int PW    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_kind,
    input  logic [$clog2(NID)-1:0]  cfg_id,
    input  logic [CFG_DATA_W-1:0]   cfg_wdata,
    output logic [NID-1:0]          en,
    output logic [PW-1:0]           prio [NID],
    output logic [NCORE-1:0]        tgt [NID-BANKED_IDS],
    output logic [NCORE-1:0]        sgi_hit [SGI_IDS]
);
    localparam int NSHR = NID - BANKED_IDS;

    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
            for (int i = 0; i < NID; i++) prio[i] <= '0;
            for (int j = 0; j < NSHR; j++) tgt[j] <= '0;
        end else if (cfg_we) begin
            case (kind)
                CFG_ENABLE: begin
                    for (int i = 0; i < NID; i++)
                        if (int'(cfg_id) == i) en[i] <= cfg_wdata[0];
                end
                CFG_PRIORITY: begin
                    for (int i = 0; i < NID; i++)
                        if (int'(cfg_id) == i) prio[i] <= cfg_wdata[PW-1:0];
                end
                CFG_TARGET: begin
                    for (int j = 0; j < NSHR; j++)
                        if (int'(cfg_id) == BANKED_IDS + j) tgt[j] <= cfg_wdata[NCORE-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int s = 0; s < SGI_IDS; s++) begin
            if (cfg_we && kind == CFG_SOFTREQ && int'(cfg_id) == s)
                sgi_hit[s] = cfg_wdata[NCORE-1:0];
            else
                sgi_hit[s] = '0;
        end
    end

endmodule

// File: rtl/intr_dist_state.sv
module intr_dist_state
    import intr_dist_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int NID   = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NID-BANKED_IDS-1:0]  spi_line,
    input  logic [NCORE*PPI_IDS-1:0]   ppi_line,
    input  logic [NCORE-1:0]           sgi_hit [SGI_IDS],
    input  logic [NID-1:0]             en,
    input  logic [NCORE-1:0]           tgt [NID-BANKED_IDS],
    input  logic [NCORE-1:0]           ack,
    input  pick_t                      pick [NCORE],
    input  logic [NCORE-1:0]           eoi,
    input  logic [ID_OUT_W-1:0]        eoi_id [NCORE],
    output logic [NID-1:0]             cand [NCORE],
    output logic [NCORE-1:0]           ack_won
);
    localparam int NSHR  = NID - BANKED_IDS;
    localparam int OWN_W = (NCORE > 1) ? $clog2(NCORE) : 1;

    irq_state_e             bst [NCORE][BANKED_IDS];
    irq_state_e             sst [NSHR];
    logic [OWN_W-1:0]       own [NSHR];
    logic [NSHR-1:0]        spi_q;
    logic [NCORE*PPI_IDS-1:0] ppi_q;

    logic [NSHR-1:0]          spi_rise;
    logic [NCORE*PPI_IDS-1:0] ppi_rise;
    logic [NCORE-1:0]         busy;
    logic [BANKED_IDS-1:0]    bset [NCORE];
    logic [BANKED_IDS-1:0]    btake [NCORE];
    logic [BANKED_IDS-1:0]    bdone [NCORE];
    logic [NSHR-1:0]          stake;
    logic [NSHR-1:0]          sdone;
    logic [OWN_W-1:0]         swin [NSHR];

    assign spi_rise = spi_line & ~spi_q;
    assign ppi_rise = ppi_line & ~ppi_q;

    // per-core busy flag and candidate vectors
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            busy[c] = 1'b0;
            for (int i = 0; i < BANKED_IDS; i++)
                if (is_active(bst[c][i])) busy[c] = 1'b1;
            for (int j = 0; j < NSHR; j++)
                if (is_active(sst[j]) && own[j] == OWN_W'(c)) busy[c] = 1'b1;
        end
        for (int c = 0; c < NCORE; c++) begin
            for (int i = 0; i < BANKED_IDS; i++)
                cand[c][i] = en[i] && (bst[c][i] == ST_PEND);
            for (int j = 0; j < NSHR; j++)
                cand[c][BANKED_IDS+j] = en[BANKED_IDS+j] && (sst[j] == ST_PEND) && tgt[j][c] &&
                                        (!busy[c] || ((tgt[j] & ~busy) == '0));
        end
    end

    // acknowledge arbitration and strobe decode
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            ack_won[c] = ack[c] && pick[c].valid;
            for (int k = 0; k < c; k++)
                if (ack[k] && pick[k].valid && pick[k].id == pick[c].id &&
                    int'(pick[c].id) >= BANKED_IDS)
                    ack_won[c] = 1'b0;
        end
        for (int c = 0; c < NCORE; c++) begin
            for (int s = 0; s < SGI_IDS; s++) bset[c][s] = sgi_hit[s][c];
            for (int p = 0; p < PPI_IDS; p++) bset[c][SGI_IDS+p] = ppi_rise[c*PPI_IDS+p];
            for (int i = 0; i < BANKED_IDS; i++) begin
                btake[c][i] = ack_won[c] && int'(pick[c].id) == i;
                bdone[c][i] = eoi[c] && int'(eoi_id[c]) == i;
            end
        end
        for (int j = 0; j < NSHR; j++) begin
            stake[j] = 1'b0;
            sdone[j] = 1'b0;
            swin[j]  = '0;
            for (int c = 0; c < NCORE; c++) begin
                if (ack_won[c] && int'(pick[c].id) == BANKED_IDS + j) begin
                    stake[j] = 1'b1;
                    swin[j]  = OWN_W'(c);
                end
                if (eoi[c] && int'(eoi_id[c]) == BANKED_IDS + j && own[j] == OWN_W'(c))
                    sdone[j] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spi_q <= '0;
            ppi_q <= '0;
            for (int c = 0; c < NCORE; c++)
                for (int i = 0; i < BANKED_IDS; i++) bst[c][i] <= ST_IDLE;
            for (int j = 0; j < NSHR; j++) begin
                sst[j] <= ST_IDLE;
                own[j] <= '0;
            end
        end else begin
            spi_q <= spi_line;
            ppi_q <= ppi_line;
            for (int c = 0; c < NCORE; c++)
                for (int i = 0; i < BANKED_IDS; i++)
                    bst[c][i] <= state_next(bst[c][i], bset[c][i], btake[c][i], bdone[c][i]);
            for (int j = 0; j < NSHR; j++) begin
                sst[j] <= state_next(sst[j], spi_rise[j], stake[j], sdone[j]);
                if (stake[j]) own[j] <= swin[j];
            end
        end
    end

endmodule

// File: rtl/intr_dist_sel.sv
module intr_dist_sel
    import intr_dist_pkg::*;
#(
    parameter int NID = 64,
    parameter int PW  = 4
) (
    input  logic [NID-1:0] cand,
    input  logic [PW-1:0]  prio [NID],
    input  logic [PW-1:0]  pmask,
    output pick_t          pick
);
    logic [PW-1:0] best;

    // ascending scan with strict compare: lower ID keeps a tie
    always_comb begin
        pick.valid = 1'b0;
        pick.id    = ID_OUT_W'(SPURIOUS);
        best       = '1;
        for (int i = 0; i < NID; i++) begin
            if (cand[i] && prio[i] < pmask && (!pick.valid || prio[i] < best)) begin
                pick.valid = 1'b1;
                pick.id    = ID_OUT_W'(i);
                best       = prio[i];
            end
        end
    end

endmodule

// File: rtl/intr_dist.sv
module intr_dist
    import intr_dist_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int NID   = 64,
    parameter int PW    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NID-32-1:0]             spi_line,
    input  logic [NCORE*16-1:0]           ppi_line,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_kind,
    input  logic [$clog2(NID)-1:0]        cfg_id,
    input  logic [7:0]                    cfg_wdata,
    input  logic [NCORE*PW-1:0]           pri_mask,
    input  logic [NCORE-1:0]              ack,
    input  logic [NCORE-1:0]              eoi,
    input  logic [NCORE*10-1:0]           eoi_id,
    output logic [NCORE-1:0]              irq_n,
    output logic [NCORE*10-1:0]           pend_id,
    output logic [NCORE*10-1:0]           ack_id
);
    localparam int NSHR = NID - BANKED_IDS;

    logic [NID-1:0]        en;
    logic [PW-1:0]         prio [NID];
    logic [NCORE-1:0]      tgt [NSHR];
    logic [NCORE-1:0]      sgi_hit [SGI_IDS];
    logic [NID-1:0]        cand [NCORE];
    logic [NCORE-1:0]      ack_won;
    pick_t                 pick [NCORE];
    logic [ID_OUT_W-1:0]   eoi_vec [NCORE];

    intr_dist_cfg #(.NCORE(NCORE), .NID(NID), .PW(PW)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_id(cfg_id),
        .cfg_wdata(cfg_wdata), .en(en), .prio(prio), .tgt(tgt), .sgi_hit(sgi_hit)
    );

    intr_dist_state #(.NCORE(NCORE), .NID(NID)) u_state (
        .clk(clk), .rst(rst), .spi_line(spi_line), .ppi_line(ppi_line), .sgi_hit(sgi_hit),
        .en(en), .tgt(tgt), .ack(ack), .pick(pick), .eoi(eoi), .eoi_id(eoi_vec),
        .cand(cand), .ack_won(ack_won)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign eoi_vec[c] = eoi_id[c*ID_OUT_W +: ID_OUT_W];

        intr_dist_sel #(.NID(NID), .PW(PW)) u_sel (
            .cand(cand[c]), .prio(prio), .pmask(pri_mask[c*PW +: PW]), .pick(pick[c])
        );

        assign irq_n[c]                        = ~pick[c].valid;
        assign pend_id[c*ID_OUT_W +: ID_OUT_W] = pick[c].id;

        always_ff @(posedge clk) begin
            if (rst)
                ack_id[c*ID_OUT_W +: ID_OUT_W] <= ID_OUT_W'(SPURIOUS);
            else if (ack[c])
                ack_id[c*ID_OUT_W +: ID_OUT_W] <= ack_won[c] ? pick[c].id : ID_OUT_W'(SPURIOUS);
        end
    end

endmodule

// File: rtl/intr_dist_chk.sv
module intr_dist_chk #(
    parameter int NCORE = 2,
    parameter int NID   = 64,
    parameter int PW    = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCORE-1:0]       ack,
    input logic [NCORE-1:0]       irq_n,
    input logic [NCORE*10-1:0]    pend_id,
    input logic [NCORE*10-1:0]    ack_id,
    input logic [NCORE*PW-1:0]    pri_mask
);
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        a_r5_empty_ack_spurious: assert property (@(posedge clk) disable iff (rst)
            (ack[c] && irq_n[c]) |=> (ack_id[c*10 +: 10] == 10'd1023));

        a_r5_acked_not_shown_again: assert property (@(posedge clk) disable iff (rst)
            (ack[c] && !irq_n[c]) |=> (pend_id[c*10 +: 10] != $past(pend_id[c*10 +: 10])));

        a_r4_zero_mask_quiet: assert property (@(posedge clk) disable iff (rst)
            (pri_mask[c*PW +: PW] == '0) |-> irq_n[c]);

        a_r2_request_has_valid_id: assert property (@(posedge clk) disable iff (rst)
            !irq_n[c] |-> (int'(pend_id[c*10 +: 10]) < NID));

        a_r1_idle_reads_spurious: assert property (@(posedge clk) disable iff (rst)
            irq_n[c] |-> (pend_id[c*10 +: 10] == 10'd1023));
    end

    a_r5_first_core_gets_shown_id: assert property (@(posedge clk) disable iff (rst)
        (ack[0] && !irq_n[0]) |=> (ack_id[9:0] == $past(pend_id[9:0])));

    if (NCORE > 1) begin : g_pair
        a_r9_lower_core_wins: assert property (@(posedge clk) disable iff (rst)
            (ack[0] && ack[1] && !irq_n[0] && !irq_n[1] && pend_id[9:0] == pend_id[19:10] &&
             int'(pend_id[9:0]) >= 32) |=> (ack_id[19:10] == 10'd1023));
    end

endmodule

bind intr_dist intr_dist_chk #(.NCORE(NCORE), .NID(NID), .PW(PW)) u_chk (
    .clk(clk), .rst(rst), .ack(ack), .irq_n(irq_n), .pend_id(pend_id),
    .ack_id(ack_id), .pri_mask(pri_mask)
);

// File: tb/intr_dist_test.sv
module intr_dist_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int NI = 64;
    localparam int PWB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NI-33:0]   spi_line = '0;
    logic [NC*16-1:0] ppi_line = '0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_kind = '0;
    logic [5:0]       cfg_id = '0;
    logic [7:0]       cfg_wdata = '0;
    logic [NC*PWB-1:0] pri_mask = '1;
    logic [NC-1:0]    ack = '0;
    logic [NC-1:0]    eoi = '0;
    logic [NC*10-1:0] eoi_id = '0;
    logic [NC-1:0]    irq_n;
    logic [NC*10-1:0] pend_id;
    logic [NC*10-1:0] ack_id;

    int n_checks = 0;
    int n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_dist #(.NCORE(NC), .NID(NI), .PW(PWB)) uut (
        .clk(clk), .rst(rst), .spi_line(spi_line), .ppi_line(ppi_line), .cfg_we(cfg_we),
        .cfg_kind(cfg_kind), .cfg_id(cfg_id), .cfg_wdata(cfg_wdata), .pri_mask(pri_mask),
        .ack(ack), .eoi(eoi), .eoi_id(eoi_id), .irq_n(irq_n), .pend_id(pend_id), .ack_id(ack_id)
    );

    // ---------------- reference model ----------------
    int m_b [NC][32];
    int m_s [32];
    int m_o [32];
    int m_pr [64];
    bit m_en [64];
    bit [1:0] m_tg [32];
    int m_ack [NC];
    bit [31:0] m_pspi;
    bit [31:0] m_pppi;

    function automatic int f_nx(int cur, bit set, bit take, bit done);
        if (cur == 0) return set ? 1 : 0;
        if (cur == 1) return take ? (set ? 3 : 2) : 1;
        if (cur == 2) return done ? (set ? 1 : 0) : (set ? 3 : 2);
        return done ? 1 : 3;
    endfunction

    function automatic bit f_busy(int c);
        for (int i = 0; i < 32; i++) if (m_b[c][i] >= 2) return 1'b1;
        for (int j = 0; j < 32; j++) if (m_s[j] >= 2 && m_o[j] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int f_sel(int c);
        bit [1:0] bz;
        int best_id;
        int best_pr;
        int msk;
        bit ok;
        bz[0] = f_busy(0);
        bz[1] = f_busy(1);
        msk = int'(pri_mask[c*PWB +: PWB]);
        best_id = 1023;
        best_pr = 99;
        for (int i = 0; i < 64; i++) begin
            if (i < 32) ok = m_en[i] && m_b[c][i] == 1;
            else ok = m_en[i] && m_s[i-32] == 1 && m_tg[i-32][c] &&
                      (!bz[c] || ((m_tg[i-32] & ~bz) == 2'b00));
            if (ok && m_pr[i] < msk && m_pr[i] < best_pr) begin
                best_pr = m_pr[i];
                best_id = i;
            end
        end
        return best_id;
    endfunction

    task automatic m_reset();
        for (int c = 0; c < NC; c++) begin
            m_ack[c] = 1023;
            for (int i = 0; i < 32; i++) m_b[c][i] = 0;
        end
        for (int j = 0; j < 32; j++) begin
            m_s[j] = 0; m_o[j] = 0; m_tg[j] = 2'b00;
        end
        for (int i = 0; i < 64; i++) begin
            m_pr[i] = 0; m_en[i] = 1'b0;
        end
        m_pspi = '0;
        m_pppi = '0;
    endtask

    task automatic m_step();
        int hp [NC];
        bit won [NC];
        bit set, tk, dn;
        int w, eid;
        for (int c = 0; c < NC; c++) hp[c] = f_sel(c);
        for (int c = 0; c < NC; c++) won[c] = ack[c] && hp[c] != 1023;
        if (won[1] && ack[0] && hp[0] == hp[1] && hp[1] >= 32) won[1] = 1'b0;
        for (int c = 0; c < NC; c++) if (ack[c]) m_ack[c] = won[c] ? hp[c] : 1023;
        for (int c = 0; c < NC; c++) begin
            eid = int'(eoi_id[c*10 +: 10]);
            for (int i = 0; i < 32; i++) begin
                if (i < 16) set = cfg_we && cfg_kind == 2'd3 && int'(cfg_id) == i && cfg_wdata[c];
                else set = ppi_line[c*16 + i - 16] && !m_pppi[c*16 + i - 16];
                tk = won[c] && hp[c] == i;
                dn = eoi[c] && eid == i;
                m_b[c][i] = f_nx(m_b[c][i], set, tk, dn);
            end
        end
        for (int j = 0; j < 32; j++) begin
            set = spi_line[j] && !m_pspi[j];
            tk = 1'b0; dn = 1'b0; w = 0;
            for (int c = 0; c < NC; c++) begin
                if (won[c] && hp[c] == 32 + j) begin tk = 1'b1; w = c; end
                if (eoi[c] && int'(eoi_id[c*10 +: 10]) == 32 + j && m_o[j] == c) dn = 1'b1;
            end
            m_s[j] = f_nx(m_s[j], set, tk, dn);
            if (tk) m_o[j] = w;
        end
        if (cfg_we) begin
            if (cfg_kind == 2'd0) m_en[int'(cfg_id)] = cfg_wdata[0];
            if (cfg_kind == 2'd1) m_pr[int'(cfg_id)] = int'(cfg_wdata[3:0]);
            if (cfg_kind == 2'd2 && cfg_id >= 6'd32) m_tg[int'(cfg_id) - 32] = cfg_wdata[1:0];
        end
        m_pspi = spi_line;
        m_pppi = ppi_line;
    endtask

    // ---------------- helpers ----------------
    function automatic int pend(int c);
        return int'(pend_id[c*10 +: 10]);
    endfunction

    function automatic int ackd(int c);
        return int'(ack_id[c*10 +: 10]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        ack = '0;
        eoi = '0;
        cfg_we = 1'b0;
    endtask

    task automatic wcfg(int kind, int id, int data);
        cfg_we = 1'b1;
        cfg_kind = 2'(kind);
        cfg_id = 6'(id);
        cfg_wdata = 8'(data);
        cyc();
    endtask

    task automatic spi_pulse(int id);
        spi_line[id-32] = 1'b1;
        cyc();
        spi_line[id-32] = 1'b0;
        cyc();
    endtask

    task automatic end_irq(int c, int id);
        eoi[c] = 1'b1;
        eoi_id[c*10 +: 10] = 10'(id);
        cyc();
    endtask

    task automatic set_mask(int c, int v);
        pri_mask[c*PWB +: PWB] = 4'(v);
        #1;
    endtask

    function automatic int pool_id();
        int r;
        r = int'($urandom % 10);
        if (r < 4) return r;
        if (r < 6) return 16 + r - 4;
        return 32 + r - 6;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1 irq_n", int'(irq_n), 3);
        chk("R1 pend0", pend(0), 1023);
        chk("R1 pend1", pend(1), 1023);
        chk("R1 ack_id0", ackd(0), 1023);

        // R2 shared presentation, R10 config encodings
        for (int id = 40; id <= 42; id++) begin
            wcfg(0, id, 1);
            wcfg(2, id, 3);
        end
        wcfg(1, 40, 5);
        wcfg(1, 41, 3);
        wcfg(1, 42, 3);
        spi_pulse(40);
        chk("R2 pend0 id40", pend(0), 40);
        chk("R2 irq_n low", int'(irq_n), 0);
        spi_pulse(42);
        spi_pulse(41);
        chk("R3 tie lower id", pend(0), 41);
        chk("R3 tie core1", pend(1), 41);

        // R4 mask
        set_mask(0, 3);
        chk("R4 mask equal blocks", pend(0), 1023);
        chk("R4 other core unaffected", pend(1), 41);
        set_mask(0, 4);
        chk("R4 mask above passes", pend(0), 41);
        set_mask(0, 15);

        // R5 ack, R8 steering
        ack[0] = 1'b1;
        cyc();
        chk("R5 ack_id0", ackd(0), 41);
        chk("R8 busy core skipped", pend(0), 1023);
        chk("R8 free core gets shared", pend(1), 42);
        // R6 re-assert while active
        spi_pulse(41);
        chk("R6 active-pending hidden", pend(1), 42);
        ack[1] = 1'b1;
        cyc();
        chk("R5 ack_id1", ackd(1), 42);
        chk("R8 all busy core0", pend(0), 40);
        chk("R8 all busy core1", pend(1), 40);
        // R9 simultaneous ack
        ack = 2'b11;
        cyc();
        chk("R9 winner core0", ackd(0), 40);
        chk("R9 loser core1", ackd(1), 1023);
        // R6 end of active-pending
        end_irq(0, 41);
        chk("R6 back to pending", pend(0), 41);
        end_irq(1, 40);
        chk("R6 non-owner end ignored", pend(1), 41);
        end_irq(0, 40);
        end_irq(1, 42);
        ack[0] = 1'b1;
        cyc();
        chk("R5 ack_id0 again", ackd(0), 41);
        end_irq(0, 41);
        chk("R6 idle after end c0", pend(0), 1023);
        chk("R6 idle after end c1", pend(1), 1023);

        // R7 software request and private line
        wcfg(0, 3, 1);
        wcfg(1, 3, 2);
        wcfg(3, 3, 2);
        chk("R7 sgi target core1", pend(1), 3);
        chk("R7 sgi not core0", pend(0), 1023);
        wcfg(0, 20, 1);
        wcfg(1, 20, 1);
        ppi_line[4] = 1'b1;
        cyc();
        ppi_line[4] = 1'b0;
        chk("R7 private core0", pend(0), 20);
        chk("R7 private not core1", pend(1), 3);

        // R10 enable gates presentation only
        wcfg(1, 50, 0);
        wcfg(2, 50, 3);
        spi_pulse(50);
        chk("R10 disabled hidden", pend(0), 20);
        wcfg(0, 50, 1);
        chk("R10 enabled shows", pend(0), 50);

        // R5 spurious ack changes nothing
        set_mask(0, 0);
        chk("R4 zero mask", int'(irq_n[0]), 1);
        ack[0] = 1'b1;
        cyc();
        chk("R5 spurious ack", ackd(0), 1023);
        set_mask(0, 15);
        chk("R5 state kept", pend(0), 50);

        // random phase against model
        rst = 1'b1;
        spi_line = '0;
        ppi_line = '0;
        pri_mask = '1;
        cyc();
        cyc();
        rst = 1'b0;
        m_reset();
        for (int it = 0; it < 3000; it++) begin
            for (int j = 0; j < 4; j++) if ($urandom % 4 == 0) spi_line[j] = ~spi_line[j];
            for (int c = 0; c < NC; c++)
                for (int p = 0; p < 2; p++)
                    if ($urandom % 5 == 0) ppi_line[c*16 + p] = ~ppi_line[c*16 + p];
            if ($urandom % 3 == 0) begin
                cfg_we = 1'b1;
                cfg_kind = 2'($urandom % 4);
                cfg_id = 6'(pool_id());
                cfg_wdata = 8'($urandom % 16);
                if ($urandom % 2 == 0 && cfg_kind == 2'd0) cfg_wdata = 8'd1;
            end
            for (int c = 0; c < NC; c++) begin
                if ($urandom % 8 == 0) pri_mask[c*PWB +: PWB] = 4'($urandom % 16);
                if ($urandom % 8 == 0) pri_mask[c*PWB +: PWB] = 4'hF;
                ack[c] = ($urandom % 3 == 0);
                eoi[c] = ($urandom % 3 == 0);
                eoi_id[c*10 +: 10] = 10'(pool_id());
            end
            m_step();
            cyc();
            for (int c = 0; c < NC; c++) begin
                chk("R3 model pend_id", pend(c), f_sel(c));
                chk("R5 model ack_id", ackd(c), m_ack[c]);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule